// File: doc/BRIEF.md
# I-Structure Memory Bank

This block is a single-assignment memory bank for a dataflow machine. Every cell in its lower region carries a presence state (empty, reserved, full or waiting) next to a 16-bit value. A request names an address, an operation, a flags word, a data word and a return route. Any response goes back on a route.

A read that finds its cell full returns the value at once. A read that finds its cell not yet full is parked. The bank keeps that one parked read, and the next write to the cell answers it on the route the read supplied. Atomic read-increment, read-decrement and compare-and-swap work on full cells below a configurable limit. Addresses at or above the tier boundary form a plain raw store with no presence tracking.

Requests are accepted one per cycle. Each request spends one cycle being taken in and one cycle being processed. When it produces a result, it spends one more cycle presenting that result.

Top module: `ism_bank`

## Requirements
- R1: A read (op code 0) of a tracked cell in the full state returns the cell value on `rsp_data` with `rsp_err` low and the request's route on `rsp_route`. `rsp_valid` rises in the third cycle after the request is sampled.
- R2: A read of a tracked cell that is empty or reserved gives no response and parks the request. The next write (op code 1) to that cell stores the value, makes the cell full, and answers the parked read with the written value on the parked route, three cycles after the write. A write to a cell with no parked read gives no response.
- R3: A clear (op code 2) of a tracked cell makes it empty and gives no response. If the cell held the parked read, the clear cancels it, so a later write to that cell gives no response.
- R4: While one read is parked, another read of a non-full tracked cell gets an error response (`rsp_err` high, `rsp_data` zero, the request's route). The first parked read is kept.
- R5: Read-increment (op code 4) and read-decrement (op code 5) on a full cell return the old value and store the old value plus or minus one, wrapping modulo 2^16.
- R6: Compare-and-swap (op code 6) on a full cell returns the old value. It stores the data word only when the flags word equals the old value.
- R7: An atomic operation on a cell that is not full, or at an address at or above the atomic limit (default 256), gets an error response and changes nothing.
- R8: Addresses at or above the tier boundary (default 256) are raw storage. A write there stores the value without a response. A read there always returns the last value written, with no error.
- R9: A clear, reserve or atomic at a raw-tier address, and the unused op code 7 at any address, get an error response and change no state.
- R10: A reserve (op code 3) moves an empty tracked cell to reserved. A read of a reserved cell is parked like a read of an empty cell.
- R11: After reset every tracked cell is empty, no read is parked, and `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Operation code |
| req_addr | input | AW (9) | Cell address |
| req_flags | input | DW (16) | Expected value for compare-and-swap |
| req_data | input | DW (16) | Write or swap data |
| req_route | input | RW (8) | Return route for any response |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_err | output | 1 | Response is an error indication |
| rsp_data | output | DW (16) | Returned value, zero on error |
| rsp_route | output | RW (8) | Route the response travels on |

## Verification
The bench parks a read and then satisfies it with a write. A design that answered on the write's route, or answered the write itself, would put the wrong route or an extra response on the port. It issues a second deferred read while one is outstanding; a design that overwrote the first parked read would answer the wrong route when the first cell is written. It clears a waiting cell and then writes it, which exposes a design that still answers the cancelled read. It also drives atomics at the wrap point of 0xFFFF, compare-and-swap with a matching and a mismatching flags word, and atomics and presence operations on reserved and raw-tier cells. An off-by-one in the wrap, or a write-back on mismatch or on error, shows up as a wrong value on a follow-up read.

// File: rtl/ism_pkg.sv
package ism_pkg;

   typedef enum logic [2:0] {
      OP_READ    = 3'd0,
      OP_WRITE   = 3'd1,
      OP_CLEAR   = 3'd2,
      OP_RESERVE = 3'd3,
      OP_RDINC   = 3'd4,
      OP_RDDEC   = 3'd5,
      OP_CAS     = 3'd6,
      OP_UNUSED  = 3'd7
   } ism_op_e;

   typedef enum logic [1:0] {
      CELL_EMPTY    = 2'd0,
      CELL_RESERVED = 2'd1,
      CELL_FULL     = 2'd2,
      CELL_WAITING  = 2'd3
   } cell_st_e;

endpackage

// File: rtl/ism_ingress.sv
module ism_ingress #(
   parameter int AW = 9,
   parameter int DW = 16,
   parameter int RW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic [2:0]    in_op,
   input  logic [AW-1:0] in_addr,
   input  logic [DW-1:0] in_flags,
   input  logic [DW-1:0] in_data,
   input  logic [RW-1:0] in_route,
   output logic          q_valid,
   output logic [2:0]    q_op,
   output logic [AW-1:0] q_addr,
   output logic [DW-1:0] q_flags,
   output logic [DW-1:0] q_data,
   output logic [RW-1:0] q_route
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_valid <= 1'b0;
         q_op    <= '0;
         q_addr  <= '0;
         q_flags <= '0;
         q_data  <= '0;
         q_route <= '0;
      end else begin
         q_valid <= in_valid;
         if (in_valid) begin
            q_op    <= in_op;
            q_addr  <= in_addr;
            q_flags <= in_flags;
            q_data  <= in_data;
            q_route <= in_route;
         end
      end
   end

endmodule

// File: rtl/ism_cells.sv
module ism_cells
   import ism_pkg::*;
#(
   parameter int DEPTH = 512,
   parameter int DW    = 16,
   parameter int TIER  = 256,
   parameter int AW    = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] addr,
   output logic [DW-1:0] rd_data,
   output cell_st_e      rd_state,
   input  logic          d_we,
   input  logic [DW-1:0] d_wdata,
   input  logic          p_we,
   input  cell_st_e      p_wstate
);

   logic [DW-1:0] mem [DEPTH];

   assign rd_data = mem[addr];

   always_ff @(posedge clk) begin
      if (d_we) mem[addr] <= d_wdata;
   end

   generate
      if (TIER > 0) begin : g_presence
         localparam int PW = (TIER > 1) ? $clog2(TIER) : 1;
         cell_st_e pres [TIER];
         logic [PW-1:0] pidx;

         assign pidx     = addr[PW-1:0];
         assign rd_state = pres[pidx];

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < TIER; i++) pres[i] <= CELL_EMPTY;
            end else if (p_we) begin
               pres[pidx] <= p_wstate;
            end
         end
      end else begin : g_all_raw
         assign rd_state = CELL_EMPTY;
      end
   endgenerate

endmodule

// File: rtl/ism_exec.sv
module ism_exec
   import ism_pkg::*;
#(
   parameter int AW   = 9,
   parameter int DW   = 16,
   parameter int RW   = 8,
   parameter int TIER = 256,
   parameter int ALIM = 256
) (
   input  logic          s_valid,
   input  logic [2:0]    s_op,
   input  logic [AW-1:0] s_addr,
   input  logic [DW-1:0] s_flags,
   input  logic [DW-1:0] s_data,
   input  logic [RW-1:0] s_route,
   input  logic [DW-1:0] cur_data,
   input  cell_st_e      cur_state,
   input  logic          pend_v,
   input  logic [AW-1:0] pend_addr,
   input  logic [RW-1:0] pend_route,
   output logic          d_we,
   output logic [DW-1:0] d_wdata,
   output logic          p_we,
   output cell_st_e      p_wstate,
   output logic          pend_set,
   output logic          pend_clr,
   output logic          o_valid,
   output logic          o_err,
   output logic [DW-1:0] o_data,
   output logic [RW-1:0] o_route
);

   logic trk, atom_ok, is_full;

   assign trk     = 32'(s_addr) < TIER;
   assign is_full = trk && (cur_state == CELL_FULL);
   assign atom_ok = is_full && (32'(s_addr) < ALIM);

   always_comb begin
      d_we     = 1'b0;
      d_wdata  = s_data;
      p_we     = 1'b0;
      p_wstate = CELL_EMPTY;
      pend_set = 1'b0;
      pend_clr = 1'b0;
      o_valid  = 1'b0;
      o_err    = 1'b0;
      o_data   = '0;
      o_route  = s_route;
      if (s_valid) begin
         unique case (ism_op_e'(s_op))
            OP_READ: begin
               if (!trk || is_full) begin
                  o_valid = 1'b1;
                  o_data  = cur_data;
               end else if (pend_v) begin
                  o_valid = 1'b1;
                  o_err   = 1'b1;
               end else begin
                  p_we     = 1'b1;
                  p_wstate = CELL_WAITING;
                  pend_set = 1'b1;
               end
            end
            OP_WRITE: begin
               d_we = 1'b1;
               if (trk) begin
                  p_we     = 1'b1;
                  p_wstate = CELL_FULL;
                  if (cur_state == CELL_WAITING && pend_v && pend_addr == s_addr) begin
                     pend_clr = 1'b1;
                     o_valid  = 1'b1;
                     o_data   = s_data;
                     o_route  = pend_route;
                  end
               end
            end
            OP_CLEAR: begin
               if (!trk) begin
                  o_valid = 1'b1;
                  o_err   = 1'b1;
               end else begin
                  p_we     = 1'b1;
                  p_wstate = CELL_EMPTY;
                  if (cur_state == CELL_WAITING) pend_clr = 1'b1;
               end
            end
            OP_RESERVE: begin
               if (!trk) begin
                  o_valid = 1'b1;
                  o_err   = 1'b1;
               end else if (cur_state == CELL_EMPTY) begin
                  p_we     = 1'b1;
                  p_wstate = CELL_RESERVED;
               end
            end
            OP_RDINC, OP_RDDEC, OP_CAS: begin
               o_valid = 1'b1;
               if (!atom_ok) begin
                  o_err = 1'b1;
               end else begin
                  o_data = cur_data;
                  if (ism_op_e'(s_op) == OP_RDINC) begin
                     d_we    = 1'b1;
                     d_wdata = cur_data + 1'b1;
                  end else if (ism_op_e'(s_op) == OP_RDDEC) begin
                     d_we    = 1'b1;
                     d_wdata = cur_data - 1'b1;
                  end else begin
                     d_we    = (s_flags == cur_data);
                     d_wdata = s_data;
                  end
               end
            end
            default: begin
               o_valid = 1'b1;
               o_err   = 1'b1;
            end
         endcase
      end
   end

endmodule

// File: rtl/ism_bank.sv
module ism_bank
   import ism_pkg::*;
#(
   parameter int DEPTH = 512,
   parameter int DW    = 16,
   parameter int RW    = 8,
   parameter int TIER  = 256,
   parameter int ALIM  = 256,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic [2:0]    req_op,
   input  logic [AW-1:0] req_addr,
   input  logic [DW-1:0] req_flags,
   input  logic [DW-1:0] req_data,
   input  logic [RW-1:0] req_route,
   output logic          rsp_valid,
   output logic          rsp_err,
   output logic [DW-1:0] rsp_data,
   output logic [RW-1:0] rsp_route
);

   generate
      if (TIER > DEPTH) begin : g_bad_tier
         $error("tier boundary beyond bank depth");
      end
      if (ALIM > TIER) begin : g_bad_alim
         $error("atomic limit must lie inside the tracked tier");
      end
      if (DEPTH < 2 || DW < 1 || RW < 1) begin : g_bad_size
         $error("bank dimensions too small");
      end
   endgenerate

   logic          s_valid;
   logic [2:0]    s_op;
   logic [AW-1:0] s_addr;
   logic [DW-1:0] s_flags, s_data;
   logic [RW-1:0] s_route;

   logic [DW-1:0] cur_data;
   cell_st_e      cur_state;

   logic          d_we, p_we, pend_set, pend_clr;
   logic [DW-1:0] d_wdata;
   cell_st_e      p_wstate;
   logic          x_valid, x_err;
   logic [DW-1:0] x_data;
   logic [RW-1:0] x_route;

   logic          pend_v;
   logic [AW-1:0] pend_addr;
   logic [RW-1:0] pend_route;

   logic          r_valid, r_err;
   logic [DW-1:0] r_data;
   logic [RW-1:0] r_route;

   ism_ingress #(.AW(AW), .DW(DW), .RW(RW)) u_ingress (
      .clk(clk), .rst_n(rst_n),
      .in_valid(req_valid), .in_op(req_op), .in_addr(req_addr),
      .in_flags(req_flags), .in_data(req_data), .in_route(req_route),
      .q_valid(s_valid), .q_op(s_op), .q_addr(s_addr),
      .q_flags(s_flags), .q_data(s_data), .q_route(s_route)
   );

   ism_cells #(.DEPTH(DEPTH), .DW(DW), .TIER(TIER), .AW(AW)) u_cells (
      .clk(clk), .rst_n(rst_n), .addr(s_addr),
      .rd_data(cur_data), .rd_state(cur_state),
      .d_we(d_we), .d_wdata(d_wdata),
      .p_we(p_we), .p_wstate(p_wstate)
   );

   ism_exec #(.AW(AW), .DW(DW), .RW(RW), .TIER(TIER), .ALIM(ALIM)) u_exec (
      .s_valid(s_valid), .s_op(s_op), .s_addr(s_addr),
      .s_flags(s_flags), .s_data(s_data), .s_route(s_route),
      .cur_data(cur_data), .cur_state(cur_state),
      .pend_v(pend_v), .pend_addr(pend_addr), .pend_route(pend_route),
      .d_we(d_we), .d_wdata(d_wdata), .p_we(p_we), .p_wstate(p_wstate),
      .pend_set(pend_set), .pend_clr(pend_clr),
      .o_valid(x_valid), .o_err(x_err), .o_data(x_data), .o_route(x_route)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_v     <= 1'b0;
         pend_addr  <= '0;
         pend_route <= '0;
      end else if (pend_set) begin
         pend_v     <= 1'b1;
         pend_addr  <= s_addr;
         pend_route <= s_route;
      end else if (pend_clr) begin
         pend_v     <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         r_valid   <= 1'b0;
         r_err     <= 1'b0;
         r_data    <= '0;
         r_route   <= '0;
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_data  <= '0;
         rsp_route <= '0;
      end else begin
         r_valid   <= x_valid;
         r_err     <= x_err;
         r_data    <= x_data;
         r_route   <= x_route;
         rsp_valid <= r_valid;
         rsp_err   <= r_valid & r_err;
         rsp_data  <= r_data;
         rsp_route <= r_route;
      end
   end

endmodule

// File: rtl/ism_bank_chk.sv
module ism_bank_chk #(
   parameter int AW   = 9,
   parameter int TIER = 256,
   parameter int ALIM = 256
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_valid,
   input logic [2:0]    req_op,
   input logic [AW-1:0] req_addr,
   input logic          rsp_valid,
   input logic          rsp_err
);

   logic in_wr, in_clr_trk, in_atom_high, in_raw_rd, in_bad;

   assign in_wr        = req_valid && req_op == 3'd1;
   assign in_clr_trk   = req_valid && req_op == 3'd2 && 32'(req_addr) < TIER;
   assign in_atom_high = req_valid && req_op >= 3'd4 && req_op <= 3'd6 && 32'(req_addr) >= ALIM;
   assign in_raw_rd    = req_valid && req_op == 3'd0 && 32'(req_addr) >= TIER;
   assign in_bad       = req_valid && req_op == 3'd7;

   AST_RSP_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> $past(req_valid, 3)); // R1

   AST_WRITE_NEVER_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      $past(in_wr, 3) |-> !rsp_err); // R2

   AST_CLEAR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      $past(in_clr_trk, 3) |-> !rsp_valid); // R3

   AST_ATOM_HIGH_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      $past(in_atom_high, 3) |-> (rsp_valid && rsp_err)); // R7

   AST_RAW_READ_OK: assert property (@(posedge clk) disable iff (!rst_n)
      $past(in_raw_rd, 3) |-> (rsp_valid && !rsp_err)); // R8

   AST_UNUSED_OP_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      $past(in_bad, 3) |-> (rsp_valid && rsp_err)); // R9

endmodule

bind ism_bank ism_bank_chk #(.AW(AW), .TIER(TIER), .ALIM(ALIM)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
   .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_err(rsp_err)
);

// File: tb/ism_bank_tb.sv
module ism_bank_tb;

   localparam int AW = 9;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic [2:0]    req_op = '0;
   logic [AW-1:0] req_addr = '0;
   logic [15:0]   req_flags = '0;
   logic [15:0]   req_data = '0;
   logic [7:0]    req_route = '0;
   logic          rsp_valid, rsp_err;
   logic [15:0]   rsp_data;
   logic [7:0]    rsp_route;

   ism_bank u_dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_op(req_op), .req_addr(req_addr),
      .req_flags(req_flags), .req_data(req_data), .req_route(req_route),
      .rsp_valid(rsp_valid), .rsp_err(rsp_err),
      .rsp_data(rsp_data), .rsp_route(rsp_route)
   );

   always #4 clk = ~clk;

   typedef struct {
      int          cyc;
      logic        err;
      logic [15:0] data;
      logic [7:0]  route;
      string       tag;
   } exp_t;

   exp_t q[$];
   int   cyc = 0;
   int   n_cmp = 0;
   int   n_bad = 0;
   bit   done = 1'b0;

   always @(posedge clk) cyc <= cyc + 1;

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   endtask

   // Monitor: pops expected responses as the design produces them
   always @(negedge clk) begin
      if (rst_n && rsp_valid && !done) begin
         n_cmp++;
         if (q.size() == 0) begin
            n_bad++;
            $display("FAIL unexpected response: err=%0b data=%h route=%h cyc=%0d, expected none",
                     rsp_err, rsp_data, rsp_route, cyc);
         end else begin
            exp_t e;
            e = q.pop_front();
            if (rsp_err !== e.err || rsp_data !== e.data || rsp_route !== e.route || cyc != e.cyc) begin
               n_bad++;
               $display("FAIL %s: got err=%0b data=%h route=%h cyc=%0d, expected err=%0b data=%h route=%h cyc=%0d",
                        e.tag, rsp_err, rsp_data, rsp_route, cyc, e.err, e.data, e.route, e.cyc);
            end
         end
      end
   end

   // Driver: one request per call, optionally pushing the expected response
   task automatic issue(input logic [2:0] op, input int addr, input logic [15:0] fl,
                        input logic [15:0] dat, input logic [7:0] rt, input bit exp_rsp,
                        input logic e_err, input logic [15:0] e_data, input logic [7:0] e_route,
                        input string tag);
      req_valid = 1'b1;
      req_op    = op;
      req_addr  = AW'(addr);
      req_flags = fl;
      req_data  = dat;
      req_route = rt;
      if (exp_rsp) begin
         exp_t e;
         e.cyc = cyc + 3; e.err = e_err; e.data = e_data; e.route = e_route; e.tag = tag;
         q.push_back(e);
      end
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   initial begin
      repeat (2000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: got no finish, expected finish before 2000 cycles");
      summary();
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      n_cmp++;
      if (rsp_valid !== 1'b0) begin
         n_bad++;
         $display("FAIL R11: got rsp_valid=%0b, expected 0", rsp_valid);
      end
      // R11: cell empty after reset and nothing parked
      issue(3'd0, 1, 0, 0, 8'h09, 0, 0, 0, 0, "R11");
      issue(3'd1, 1, 0, 16'h1111, 8'h00, 1, 0, 16'h1111, 8'h09, "R11");
      // R8: raw tier
      issue(3'd1, 300, 0, 16'h1234, 8'h01, 0, 0, 0, 0, "R8");
      issue(3'd0, 300, 0, 0, 8'h11, 1, 0, 16'h1234, 8'h11, "R8");
      // R1: full-cell read
      issue(3'd1, 5, 0, 16'hABCD, 8'h01, 0, 0, 0, 0, "R1");
      issue(3'd0, 5, 0, 0, 8'h03, 1, 0, 16'hABCD, 8'h03, "R1");
      // R2: deferred read satisfied by a later write
      issue(3'd0, 10, 0, 0, 8'h07, 0, 0, 0, 0, "R2");
      idle(4);
      issue(3'd1, 10, 0, 16'h55AA, 8'h01, 1, 0, 16'h55AA, 8'h07, "R2");
      issue(3'd0, 10, 0, 0, 8'h08, 1, 0, 16'h55AA, 8'h08, "R2");
      // R4: second deferred read refused, first kept
      issue(3'd0, 20, 0, 0, 8'h02, 0, 0, 0, 0, "R4");
      issue(3'd0, 21, 0, 0, 8'h04, 1, 1, 16'h0000, 8'h04, "R4");
      issue(3'd1, 20, 0, 16'h0777, 8'h00, 1, 0, 16'h0777, 8'h02, "R4");
      // R3: clear cancels the parked read
      issue(3'd0, 30, 0, 0, 8'h05, 0, 0, 0, 0, "R3");
      issue(3'd2, 30, 0, 0, 8'h05, 0, 0, 0, 0, "R3");
      issue(3'd1, 30, 0, 16'h0042, 8'h00, 0, 0, 0, 0, "R3");
      issue(3'd0, 30, 0, 0, 8'h0C, 1, 0, 16'h0042, 8'h0C, "R3");
      // R10: reserved cell defers
      issue(3'd3, 40, 0, 0, 8'h00, 0, 0, 0, 0, "R10");
      issue(3'd0, 40, 0, 0, 8'h06, 0, 0, 0, 0, "R10");
      issue(3'd1, 40, 0, 16'h0009, 8'h00, 1, 0, 16'h0009, 8'h06, "R10");
      // R5: increment and decrement with wrap
      issue(3'd1, 50, 0, 16'hFFFF, 8'h00, 0, 0, 0, 0, "R5");
      issue(3'd4, 50, 0, 0, 8'h0A, 1, 0, 16'hFFFF, 8'h0A, "R5");
      issue(3'd0, 50, 0, 0, 8'h0A, 1, 0, 16'h0000, 8'h0A, "R5");
      issue(3'd5, 50, 0, 0, 8'h0B, 1, 0, 16'h0000, 8'h0B, "R5");
      issue(3'd0, 50, 0, 0, 8'h0B, 1, 0, 16'hFFFF, 8'h0B, "R5");
      // R6: compare-and-swap miss then hit
      issue(3'd1, 60, 0, 16'd100, 8'h00, 0, 0, 0, 0, "R6");
      issue(3'd6, 60, 16'd99, 16'd7, 8'h0D, 1, 0, 16'd100, 8'h0D, "R6");
      issue(3'd0, 60, 0, 0, 8'h0D, 1, 0, 16'd100, 8'h0D, "R6");
      issue(3'd6, 60, 16'd100, 16'd7, 8'h0E, 1, 0, 16'd100, 8'h0E, "R6");
      issue(3'd0, 60, 0, 0, 8'h0E, 1, 0, 16'd7, 8'h0E, "R6");
      // R7: atomic on non-full cell and at high address
      issue(3'd3, 71, 0, 0, 8'h00, 0, 0, 0, 0, "R7");
      issue(3'd4, 71, 0, 0, 8'h21, 1, 1, 16'h0000, 8'h21, "R7");
      issue(3'd1, 71, 0, 16'h0003, 8'h00, 0, 0, 0, 0, "R7");
      issue(3'd0, 71, 0, 0, 8'h22, 1, 0, 16'h0003, 8'h22, "R7");
      issue(3'd4, 300, 0, 0, 8'h23, 1, 1, 16'h0000, 8'h23, "R7");
      issue(3'd0, 300, 0, 0, 8'h24, 1, 0, 16'h1234, 8'h24, "R7");
      // R9: presence ops on raw tier and unused op code
      issue(3'd2, 300, 0, 0, 8'h31, 1, 1, 16'h0000, 8'h31, "R9");
      issue(3'd3, 301, 0, 0, 8'h32, 1, 1, 16'h0000, 8'h32, "R9");
      issue(3'd0, 300, 0, 0, 8'h33, 1, 0, 16'h1234, 8'h33, "R9");
      issue(3'd7, 5, 0, 16'h0BAD, 8'h34, 1, 1, 16'h0000, 8'h34, "R9");
      issue(3'd0, 5, 0, 0, 8'h35, 1, 0, 16'hABCD, 8'h35, "R9");
      idle(8);
      n_cmp++;
      if (q.size() != 0) begin
         n_bad++;
         $display("FAIL R2: got %0d responses still owed, expected 0", q.size());
      end
      summary();
   end

endmodule